// File: doc/BRIEF.md
# Hart Run-State Status Aggregator

This block keeps the run state of a small set of harts on behalf of a debug controller and folds it into combined status bits. Each hart slot holds a two-state run machine (RUNNING, HALTED) plus a resume-acknowledge bit, a have-reset bit, a halt-group number, a halt-request line and a pending-resume flag. Harts report events through a notification port: a 2-bit kind plus the hart index. The debugger side supplies a selected index, an optional selection mask with its enable, control writes that carry halt and resume requests, and halt-group writes.

The per-slot machine has two transitions. RUNNING goes to HALTED on a halted notification. HALTED goes back to RUNNING on a resuming notification or a reset notification. If a hart with a nonzero halt group enters HALTED, every other existing hart in that group that is still running gets a halt request. The status outputs are combinational from the registered slot state and the current selection inputs. They summarise only the harts that are both selected and existing.

The index field is `$clog2(NUM_HARTS)` bits wide, with a minimum of 1. State exists for all `2**IDX_W` slots, so an index that names a nonexistent hart is accepted without harm.

Top module: `hart_run_status`

## Requirements
- R1: After synchronous active-high reset, all slots are RUNNING with resume-ack, have-reset, halt-request, resume flag and group all 0.
- R2: A notification of kind 1 (halted) for hart k moves slot k from RUNNING to HALTED on the next clock edge. A slot that is already HALTED stays HALTED.
- R3: When a halted notification finds hart k RUNNING with a nonzero group g, every other existing RUNNING hart whose group is g gets its halt-request line set on the same edge. This takes priority over a control write in the same cycle.
- R4: A notification of kind 2 (resuming) for hart k makes slot k RUNNING, sets its resume-ack bit and clears its resume flag. It overrides a resume request in the same cycle.
- R5: A control write with the resume bit set sets the resume flag and clears the resume-ack bit of every selected existing hart.
- R6: A control write loads its halt-request bit into the halt-request line of every selected existing hart. Unselected harts keep their lines. Lines at or above NUM_HARTS stay 0.
- R7: Hart j is selected when j equals the selected index. When the array enable is 1, hart j is also selected if mask bit j is 1. The mask has no effect when the enable is 0.
- R8: The all-halted, all-running and all-resume-ack bits are 1, and the any- bits are 0, when no existing hart is selected. Otherwise each bit is the AND or OR of the matching per-hart condition over the selected existing harts.
- R9: The all-nonexistent bit is 1 exactly when no existing hart is selected. The any-nonexistent bit is 1 exactly when the selected index is NUM_HARTS or more.
- R10: A notification of kind 3 (reset) for hart k sets its have-reset bit, makes it RUNNING and sets its group to 0. This overrides a group write in the same cycle.
- R11: A group write loads the selected index's group only when its write-enable is 1 and GROUPS_ON is 1. Otherwise the group is unchanged.
- R12: Both unavailable summary bits are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| note_kind | input | 2 | Notification kind: 0 idle, 1 halted, 2 resuming, 3 reset |
| note_id | input | IDX_W | Hart index of the notification |
| sel_idx | input | IDX_W | Selected hart index |
| array_en | input | 1 | Enables mask-based selection |
| array_mask | input | NUM_HARTS | Per-hart selection mask |
| ctl_wr | input | 1 | Control write strobe |
| ctl_halt | input | 1 | Halt-request bit of the control write |
| ctl_resume | input | 1 | Resume-request bit of the control write |
| grp_wr | input | 1 | Group write strobe |
| grp_wr_en | input | 1 | Write-enable bit accompanying the group write |
| grp_val | input | GROUP_W | Group number to write |
| halt_req | output | SLOTS | Per-hart halt-request lines |
| resume_flag | output | SLOTS | Per-hart pending-resume flags |
| sel_have_reset | output | 1 | Have-reset bit of the selected index |
| sel_group | output | GROUP_W | Group of the selected index |
| all_halted | output | 1 | All selected harts halted |
| any_halted | output | 1 | Some selected hart halted |
| all_running | output | 1 | All selected harts running |
| any_running | output | 1 | Some selected hart running |
| all_resack | output | 1 | All selected harts resume-acknowledged |
| any_resack | output | 1 | Some selected hart resume-acknowledged |
| all_nonexist | output | 1 | No existing hart selected |
| any_nonexist | output | 1 | Selected index is beyond the last hart |
| all_unavail | output | 1 | Always 0 |
| any_unavail | output | 1 | Always 0 |

## Verification
Every slot register changes on the first rising edge after the notification or write is presented. The status bits, `sel_have_reset` and `sel_group` are combinational from those registers and the selection inputs, so they are valid in the cycle after that edge. Selection inputs alone change the status bits without any clock. The bench drives on the falling edge and advances its own model at the rising edge. It compares every output one time step after the next falling edge, which is exactly one register stage after the stimulus. The selection sweep holds slot state fixed and checks each index, enable and mask combination in the same way.

// File: rtl/hart_stat_pkg.sv
package hart_stat_pkg;

    typedef enum logic [1:0] {
        NOTE_IDLE     = 2'd0,
        NOTE_HALTED   = 2'd1,
        NOTE_RESUMING = 2'd2,
        NOTE_RESET    = 2'd3
    } note_kind_e;

    typedef enum logic {
        RUN_ST  = 1'b0,
        HALT_ST = 1'b1
    } run_state_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/hart_slot.sv
module hart_slot
    import hart_stat_pkg::*;
#(
    parameter int GROUP_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_hit,
    input  logic               ctl_halt,
    input  logic               ctl_resume,
    input  logic               grp_hit,
    input  logic [GROUP_W-1:0] grp_val,
    input  logic               note_hit,
    input  logic [1:0]         note_kind,
    input  logic               peer_halt,
    output logic               halted,
    output logic               resack,
    output logic               have_reset,
    output logic               halt_req,
    output logic               resume_flag,
    output logic [GROUP_W-1:0] group
);

    run_state_e st_q, st_d;
    note_kind_e kind;
    logic       n_halt, n_resume, n_reset;

    assign kind     = note_kind_e'(note_kind);
    assign n_halt   = note_hit && (kind == NOTE_HALTED);
    assign n_resume = note_hit && (kind == NOTE_RESUMING);
    assign n_reset  = note_hit && (kind == NOTE_RESET);

    always_ff @(posedge clk) begin
        if (rst) st_q <= RUN_ST;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RUN_ST:  if (n_halt) st_d = HALT_ST;
            HALT_ST: if (n_resume || n_reset) st_d = RUN_ST;
        endcase
    end

    always_comb begin
        halted = (st_q == HALT_ST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resack      <= 1'b0;
            have_reset  <= 1'b0;
            halt_req    <= 1'b0;
            resume_flag <= 1'b0;
            group       <= '0;
        end else begin
            if (ctl_hit) halt_req <= ctl_halt;
            if (peer_halt) halt_req <= 1'b1;
            if (ctl_hit && ctl_resume) begin
                resume_flag <= 1'b1;
                resack      <= 1'b0;
            end
            if (n_resume) begin
                resack      <= 1'b1;
                resume_flag <= 1'b0;
            end
            if (grp_hit) group <= grp_val;
            if (n_reset) begin
                have_reset <= 1'b1;
                group      <= '0;
            end
        end
    end

    // R2
    halted_set_chk: assert property (@(posedge clk) disable iff (rst)
        n_halt |=> halted);

    // R4
    resume_note_chk: assert property (@(posedge clk) disable iff (rst)
        n_resume |=> (!halted && resack && !resume_flag));

    // R10
    reset_note_chk: assert property (@(posedge clk) disable iff (rst)
        n_reset |=> (have_reset && (group == '0) && !halted));

    // R3
    peer_halt_chk: assert property (@(posedge clk) disable iff (rst)
        peer_halt |=> halt_req);

    // R5
    resume_req_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_hit && ctl_resume && !n_resume) |=> (resume_flag && !resack));

endmodule

// File: rtl/status_merge.sv
module status_merge #(
    parameter int NUM_HARTS = 3,
    parameter int SLOTS     = 4
) (
    input  logic [SLOTS-1:0] sel,
    input  logic [SLOTS-1:0] halted,
    input  logic [SLOTS-1:0] resack,
    output logic             all_halted,
    output logic             any_halted,
    output logic             all_running,
    output logic             any_running,
    output logic             all_resack,
    output logic             any_resack,
    output logic             all_nonexist
);

    always_comb begin
        all_halted   = 1'b1;
        any_halted   = 1'b0;
        all_running  = 1'b1;
        any_running  = 1'b0;
        all_resack   = 1'b1;
        any_resack   = 1'b0;
        all_nonexist = 1'b1;
        for (int j = 0; j < SLOTS; j++) begin
            if (j < NUM_HARTS && sel[j]) begin
                all_nonexist = 1'b0;
                if (halted[j]) begin
                    any_halted  = 1'b1;
                    all_running = 1'b0;
                end else begin
                    all_halted  = 1'b0;
                    any_running = 1'b1;
                end
                if (resack[j]) any_resack = 1'b1;
                else           all_resack = 1'b0;
            end
        end
    end

endmodule

// File: rtl/hart_run_status.sv
module hart_run_status
    import hart_stat_pkg::*;
#(
    parameter int NUM_HARTS = 3,
    parameter int GROUP_W   = 2,
    parameter bit GROUPS_ON = 1'b1,
    localparam int IDX_W    = idx_width(NUM_HARTS),
    localparam int SLOTS    = 1 << IDX_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           note_kind,
    input  logic [IDX_W-1:0]     note_id,
    input  logic [IDX_W-1:0]     sel_idx,
    input  logic                 array_en,
    input  logic [NUM_HARTS-1:0] array_mask,
    input  logic                 ctl_wr,
    input  logic                 ctl_halt,
    input  logic                 ctl_resume,
    input  logic                 grp_wr,
    input  logic                 grp_wr_en,
    input  logic [GROUP_W-1:0]   grp_val,
    output logic [SLOTS-1:0]     halt_req,
    output logic [SLOTS-1:0]     resume_flag,
    output logic                 sel_have_reset,
    output logic [GROUP_W-1:0]   sel_group,
    output logic                 all_halted,
    output logic                 any_halted,
    output logic                 all_running,
    output logic                 any_running,
    output logic                 all_resack,
    output logic                 any_resack,
    output logic                 all_nonexist,
    output logic                 any_nonexist,
    output logic                 all_unavail,
    output logic                 any_unavail
);

    logic [SLOTS-1:0]   sel_vec;
    logic [SLOTS-1:0]   halted_v;
    logic [SLOTS-1:0]   resack_v;
    logic [SLOTS-1:0]   have_reset_v;
    logic [GROUP_W-1:0] group_v [SLOTS];
    logic               halt_trig;
    logic [GROUP_W-1:0] trig_group;

    // R3: a fresh halt in a nonzero group spreads to running peers
    assign trig_group = group_v[note_id];
    assign halt_trig  = (note_kind_e'(note_kind) == NOTE_HALTED)
                        && !halted_v[note_id] && (trig_group != '0);

    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
        localparam bit EXISTS = (j < NUM_HARTS);
        logic ctl_hit, grp_hit, note_hit, peer_halt;

        // R7
        if (EXISTS) begin : g_sel
            assign sel_vec[j] = (sel_idx == IDX_W'(j)) || (array_en && array_mask[j]);
        end else begin : g_sel
            assign sel_vec[j] = (sel_idx == IDX_W'(j));
        end

        assign ctl_hit   = EXISTS && ctl_wr && sel_vec[j];
        assign grp_hit   = GROUPS_ON && grp_wr && grp_wr_en && (sel_idx == IDX_W'(j));
        assign note_hit  = (note_id == IDX_W'(j));
        assign peer_halt = EXISTS && halt_trig && (note_id != IDX_W'(j))
                           && !halted_v[j] && (group_v[j] == trig_group);

        hart_slot #(.GROUP_W(GROUP_W)) u_slot (
            .clk         (clk),
            .rst         (rst),
            .ctl_hit     (ctl_hit),
            .ctl_halt    (ctl_halt),
            .ctl_resume  (ctl_resume),
            .grp_hit     (grp_hit),
            .grp_val     (grp_val),
            .note_hit    (note_hit),
            .note_kind   (note_kind),
            .peer_halt   (peer_halt),
            .halted      (halted_v[j]),
            .resack      (resack_v[j]),
            .have_reset  (have_reset_v[j]),
            .halt_req    (halt_req[j]),
            .resume_flag (resume_flag[j]),
            .group       (group_v[j])
        );
    end

    status_merge #(.NUM_HARTS(NUM_HARTS), .SLOTS(SLOTS)) u_merge (
        .sel          (sel_vec),
        .halted       (halted_v),
        .resack       (resack_v),
        .all_halted   (all_halted),
        .any_halted   (any_halted),
        .all_running  (all_running),
        .any_running  (any_running),
        .all_resack   (all_resack),
        .any_resack   (any_resack),
        .all_nonexist (all_nonexist)
    );

    assign any_nonexist   = (int'(sel_idx) >= NUM_HARTS);
    assign sel_have_reset = have_reset_v[sel_idx];
    assign sel_group      = group_v[sel_idx];
    // R12
    assign all_unavail    = 1'b0;
    assign any_unavail    = 1'b0;

    // R9
    nonexist_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (any_nonexist && !array_en) |-> all_nonexist);

    // R8
    halted_summary_chk: assert property (@(posedge clk) disable iff (rst)
        (!all_nonexist && all_halted) |-> (any_halted && !any_running));

endmodule

// File: tb/tb_hart_run_status.sv
module tb_hart_run_status;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 3;
    localparam int GW = 2;
    localparam int IW = 2;
    localparam int SL = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    note_kind = 2'd0;
    logic [IW-1:0] note_id = '0;
    logic [IW-1:0] sel_idx = '0;
    logic          array_en = 1'b0;
    logic [N-1:0]  array_mask = '0;
    logic          ctl_wr = 1'b0, ctl_halt = 1'b0, ctl_resume = 1'b0;
    logic          grp_wr = 1'b0, grp_wr_en = 1'b0;
    logic [GW-1:0] grp_val = '0;
    logic [SL-1:0] halt_req, resume_flag;
    logic          sel_have_reset;
    logic [GW-1:0] sel_group;
    logic all_halted, any_halted, all_running, any_running;
    logic all_resack, any_resack, all_nonexist, any_nonexist;
    logic all_unavail, any_unavail;

    int checks = 0;
    int errors = 0;

    bit       mh [SL], ma [SL], mhv [SL], mhr [SL], mrf [SL];
    bit [1:0] mg [SL];

    hart_run_status #(.NUM_HARTS(N), .GROUP_W(GW), .GROUPS_ON(1'b1)) dut (
        .clk(clk), .rst(rst), .note_kind(note_kind), .note_id(note_id),
        .sel_idx(sel_idx), .array_en(array_en), .array_mask(array_mask),
        .ctl_wr(ctl_wr), .ctl_halt(ctl_halt), .ctl_resume(ctl_resume),
        .grp_wr(grp_wr), .grp_wr_en(grp_wr_en), .grp_val(grp_val),
        .halt_req(halt_req), .resume_flag(resume_flag),
        .sel_have_reset(sel_have_reset), .sel_group(sel_group),
        .all_halted(all_halted), .any_halted(any_halted),
        .all_running(all_running), .any_running(any_running),
        .all_resack(all_resack), .any_resack(any_resack),
        .all_nonexist(all_nonexist), .any_nonexist(any_nonexist),
        .all_unavail(all_unavail), .any_unavail(any_unavail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit is_sel(input int j);
        return (j == int'(sel_idx)) || (array_en && j < N && array_mask[j]);
    endfunction

    task automatic model_update();
        bit       oh [SL];
        bit [1:0] og [SL];
        int       k;
        for (int j = 0; j < SL; j++) begin oh[j] = mh[j]; og[j] = mg[j]; end
        if (ctl_wr)
            for (int j = 0; j < N; j++)
                if (is_sel(j)) begin
                    mhr[j] = ctl_halt;
                    if (ctl_resume) begin mrf[j] = 1'b1; ma[j] = 1'b0; end
                end
        if (grp_wr && grp_wr_en) mg[sel_idx] = grp_val;
        k = int'(note_id);
        case (note_kind)
            2'd1: begin
                if (!oh[k] && og[k] != 0)
                    for (int j = 0; j < N; j++)
                        if (j != k && !oh[j] && og[j] == og[k]) mhr[j] = 1'b1;
                mh[k] = 1'b1;
            end
            2'd2: begin mh[k] = 1'b0; ma[k] = 1'b1; mrf[k] = 1'b0; end
            2'd3: begin mhv[k] = 1'b1; mh[k] = 1'b0; mg[k] = 2'd0; end
            default: ;
        endcase
    endtask

    task automatic compare_all();
        bit eah = 1, enh = 0, ear = 1, enr = 0, eaa = 1, ena = 0, enone = 1;
        for (int j = 0; j < N; j++)
            if (is_sel(j)) begin
                enone = 0;
                if (mh[j]) begin enh = 1; ear = 0; end else begin eah = 0; enr = 1; end
                if (ma[j]) ena = 1; else eaa = 0;
            end
        for (int j = 0; j < SL; j++) begin
            chk("R6 R3 halt_req", halt_req[j], mhr[j]);
            chk("R5 R4 resume_flag", resume_flag[j], mrf[j]);
        end
        chk("R10 sel_have_reset", sel_have_reset, mhv[sel_idx]);
        chk("R11 sel_group", sel_group, mg[sel_idx]);
        chk("R7 R8 all_halted", all_halted, eah);
        chk("R7 R8 any_halted", any_halted, enh);
        chk("R7 R8 all_running", all_running, ear);
        chk("R7 R8 any_running", any_running, enr);
        chk("R8 all_resack", all_resack, eaa);
        chk("R8 any_resack", any_resack, ena);
        chk("R9 all_nonexist", all_nonexist, enone);
        chk("R9 any_nonexist", any_nonexist, int'(sel_idx) >= N);
        chk("R12 unavail", {all_unavail, any_unavail}, 0);
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        note_kind = 2'd0; ctl_wr = 1'b0; ctl_halt = 1'b0; ctl_resume = 1'b0;
        grp_wr = 1'b0; grp_wr_en = 1'b0;
        #1;
        compare_all();
    endtask

    task automatic note(input int kind, input int id);
        note_kind = 2'(kind); note_id = IW'(id); tick();
    endtask

    task automatic gwrite(input int idx, input bit en, input int val);
        sel_idx = IW'(idx); grp_wr = 1'b1; grp_wr_en = en; grp_val = GW'(val); tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1 halt_req", halt_req, 0);
        chk("R1 resume_flag", resume_flag, 0);
        chk("R1 all_running", all_running, 1);
        chk("R1 sel_group", sel_group, 0);
        compare_all();

        // R2: halted notification
        note(1, 0);
        chk("R2 hart0 halted", all_halted, 1);
        note(1, 0);
        chk("R2 stays halted", any_halted, 1);

        // R11: group writes, gated by enable
        gwrite(0, 1, 2); gwrite(1, 1, 2); gwrite(2, 1, 2);
        gwrite(1, 0, 3);
        chk("R11 ignored without enable", sel_group, 2);

        // R3: halt of hart1 spreads to hart2 only
        note(1, 1);
        chk("R3 peer halt hart2", halt_req[2], 1);
        chk("R3 halted hart0 untouched", halt_req[0], 0);

        // R6: clear hart2 request, then repeat halt of an already halted hart
        sel_idx = 2'd2; ctl_wr = 1'b1; ctl_halt = 1'b0; tick();
        note(1, 1);
        chk("R3 no spread from halted", halt_req[2], 0);

        // R5: resume request through the mask
        sel_idx = 2'd3; array_en = 1'b1; array_mask = 3'b011;
        ctl_wr = 1'b1; ctl_resume = 1'b1; tick();
        chk("R5 flags", resume_flag, 4'b0011);

        // R4: resuming notification
        note(2, 0);
        chk("R4 hart0 ack", resume_flag[0], 0);

        // R4 beats resume request on the same hart in the same cycle
        sel_idx = 2'd0; array_en = 1'b0;
        ctl_wr = 1'b1; ctl_resume = 1'b1; note_kind = 2'd2; note_id = 2'd0; tick();

        // R10: reset notification, also against a group write
        sel_idx = 2'd1; grp_wr = 1'b1; grp_wr_en = 1'b1; grp_val = 2'd3;
        note_kind = 2'd3; note_id = 2'd1; tick();
        chk("R10 group zero", sel_group, 0);

        // R6: halt request on one index, nonexistent index has no effect
        sel_idx = 2'd2; ctl_wr = 1'b1; ctl_halt = 1'b1; tick();
        sel_idx = 2'd3; ctl_wr = 1'b1; ctl_halt = 1'b0; tick();
        chk("R6 unselected kept", halt_req[2], 1);
        note(1, 3);
        gwrite(3, 1, 1);
        note(2, 2);

        // R7 R8 R9: sweep of selection over a fixed state
        for (int s = 0; s < SL; s++)
            for (int e = 0; e < 2; e++)
                for (int m = 0; m < (1 << N); m++) begin
                    sel_idx = IW'(s); array_en = e[0]; array_mask = N'(m);
                    tick();
                end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule